// File: doc/BRIEF.md
# Run-Length Pixel Stream Expander

This block turns a stream of compressed run-length records into a plain stream of 8-bit pixels. Each record arrives as two bytes on one byte-wide input: a repeat count, then the pixel value to repeat. The block writes that value out as many times as the count says. Records enter through a valid/ready handshake, and pixels leave through another one, so a full downstream buffer stalls the expander without losing data.

The block counts the pixels of the current frame. A frame is `FRAME_W*FRAME_H` pixels, which is 640x480 by default. The block pulses a frame-done strobe when the last pixel of a frame is taken. It raises sticky error flags when the records overshoot a frame or end it short. The record source marks the final record of a frame with a last bit that travels with the value byte.

Top module: `rle_expander`

## Requirements
- R1: The first byte accepted after reset, or after a record completes, is the repeat count. The next accepted byte is the pixel value, and `inLast` is sampled together with that value byte.
- R2: A record with count N (1 to 255) produces exactly N consecutive output pixels, each equal to the value byte, in record order.
- R3: A record with count 0 produces no output pixel. It is consumed as soon as its value byte is accepted.
- R4: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` does not change. No pixel is dropped or repeated because of a stall.
- R5: `inReady` is low on every cycle on which `outValid` is high. A new record is accepted only after every pixel of the previous record has been handed off.
- R6: `frameDone` is high for exactly the cycle on which the `FRAME_W*FRAME_H`-th pixel of a frame is accepted (`outValid` and `outReady` both high). Pixel counting then restarts from zero for the next frame.
- R7: If a record holds more pixels than remain in the current frame, only the pixels that fit are emitted. The rest of that record is discarded, and `overflowFlag` goes high and stays high until reset.
- R8: If a record marked last finishes while the frame is incomplete, `underflowFlag` goes high and stays high until reset. This includes a zero-count last record. The pixel count of the frame restarts from zero.
- R9: While reset is active and just after it, `inReady` is 1, `outValid` is 0, `frameDone` is 0, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A record byte is offered |
| inData | input | 8 | Record byte: the count, then the value |
| inLast | input | 1 | With the value byte: this record closes the frame |
| inReady | output | 1 | The block takes the offered byte |
| outValid | output | 1 | A pixel is offered |
| outData | output | 8 | Pixel value |
| outReady | input | 1 | The consumer takes the pixel |
| frameDone | output | 1 | Pulse when the final pixel of a frame is taken |
| overflowFlag | output | 1 | Sticky: a record overshot the frame |
| underflowFlag | output | 1 | Sticky: a last record ended a short frame |

## Verification
Three events can fall on one handshake cycle: the frame wrap, the end of the current record, and the error decisions about that record. The bench provokes each combination directly. A last record whose final pixel is exactly the frame's final pixel must give `frameDone` and no underflow. A record that straddles the boundary must give `frameDone` and overflow together in the same cycle, and the next record must then start a fresh frame. Random records sized to fit the frame, with random consumer stalls, reach the boundary from many different record splits. Every handed-off pixel, each frame-done pulse, and each flag is compared with a model in the bench.

// File: rtl/rle_pkg.sv
package rle_pkg;

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_VALUE = 2'd1,
    ST_EMIT  = 2'd2
  } rleState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic loadVal;
    logic step;
    logic wrap;
    logic shortEnd;
    logic setOvf;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic cntZero;
    logic remOne;
    logic pixAtEnd;
    logic pixZero;
    logic lastHeld;
  } dpStatus_t;

endpackage

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        outReady,
  input  dpStatus_t   stat,
  output logic        inReady,
  output logic        outValid,
  output logic        frameDone,
  output ctrlStrobe_t strobe
);

  rleState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_COUNT;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    inReady   = 1'b0;
    outValid  = 1'b0;
    case (state)
      ST_COUNT: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.loadCnt = 1'b1;
          nextState      = ST_VALUE;
        end
      end
      ST_VALUE: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.loadVal = 1'b1;
          if (stat.cntZero) begin
            nextState = ST_COUNT;
            if (inLast && !stat.pixZero) strobe.shortEnd = 1'b1;
          end else begin
            nextState = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        outValid = 1'b1;
        if (outReady) begin
          strobe.step = 1'b1;
          if (stat.pixAtEnd) begin
            strobe.wrap = 1'b1;
            if (!stat.remOne) strobe.setOvf = 1'b1;
          end
          if (stat.remOne || stat.pixAtEnd) begin
            nextState = ST_COUNT;
            if (stat.lastHeld && !stat.pixAtEnd) strobe.shortEnd = 1'b1;
          end
        end
      end
      default: nextState = ST_COUNT;
    endcase
  end

  assign frameDone = strobe.wrap;

endmodule

// File: rtl/rle_datapath.sv
module rle_datapath
  import rle_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int FRAME_PIX = 307200,
  localparam int PC_W     = $clog2(FRAME_PIX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         stat,
  output logic [BYTE_W-1:0] outData,
  output logic              overflowFlag,
  output logic              underflowFlag
);

  logic [BYTE_W-1:0] remCnt;
  logic [BYTE_W-1:0] pixVal;
  logic              lastReg;
  logic [PC_W-1:0]   pixCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remCnt  <= '0;
      pixVal  <= '0;
      lastReg <= 1'b0;
    end else begin
      if (strobe.loadCnt)   remCnt <= inData;
      else if (strobe.step) remCnt <= remCnt - 1'b1;
      if (strobe.loadVal) begin
        pixVal  <= inData;
        lastReg <= inLast;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             pixCnt <= '0;
    else if (strobe.wrap || strobe.shortEnd) pixCnt <= '0;
    else if (strobe.step)                  pixCnt <= pixCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (strobe.setOvf)   overflowFlag  <= 1'b1;
      if (strobe.shortEnd) underflowFlag <= 1'b1;
    end
  end

  assign stat.cntZero  = (remCnt == '0);
  assign stat.remOne   = (remCnt == BYTE_W'(1));
  assign stat.pixAtEnd = (pixCnt == PC_W'(FRAME_PIX - 1));
  assign stat.pixZero  = (pixCnt == '0);
  assign stat.lastHeld = lastReg;
  assign outData       = pixVal;

endmodule

// File: rtl/rle_expander.sv
module rle_expander
  import rle_pkg::*;
#(
  parameter int FRAME_W   = 640,
  parameter int FRAME_H   = 480,
  parameter int BYTE_W    = 8,
  localparam int FRAME_PIX = FRAME_W * FRAME_H
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  input  logic              outReady,
  output logic              frameDone,
  output logic              overflowFlag,
  output logic              underflowFlag
);

  ctrlStrobe_t strobe;
  dpStatus_t   stat;

  rle_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .stat     (stat),
    .inReady  (inReady),
    .outValid (outValid),
    .frameDone(frameDone),
    .strobe   (strobe)
  );

  rle_datapath #(
    .BYTE_W   (BYTE_W),
    .FRAME_PIX(FRAME_PIX)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inData       (inData),
    .inLast       (inLast),
    .strobe       (strobe),
    .stat         (stat),
    .outData      (outData),
    .overflowFlag (overflowFlag),
    .underflowFlag(underflowFlag)
  );

endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic [BYTE_W-1:0] outData,
  input logic              outReady,
  input logic              frameDone,
  input logic              overflowFlag,
  input logic              underflowFlag
);

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  assert_no_intake_while_emit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_done_on_handshake_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> outValid && outReady);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |=> underflowFlag);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> !outValid && !overflowFlag && !underflowFlag);

endmodule

bind rle_expander rle_expander_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inReady      (inReady),
  .outValid     (outValid),
  .outData      (outData),
  .outReady     (outReady),
  .frameDone    (frameDone),
  .overflowFlag (overflowFlag),
  .underflowFlag(underflowFlag)
);

// File: tb/test_rle_expander.sv
module test_rle_expander;

  localparam int FW = 6;
  localparam int FH = 4;
  localparam int FP = FW * FH;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic       outValid;
  logic [7:0] outData;
  logic       outReady = 1'b0;
  logic       frameDone;
  logic       overflowFlag;
  logic       underflowFlag;

  rle_expander #(.FRAME_W(FW), .FRAME_H(FH)) i_rle_expander (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outReady(outReady),
    .frameDone(frameDone), .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  always #5 clk = ~clk;

  int  nChecks = 0;
  int  nFails  = 0;
  int  readyPct = 75;
  logic [7:0] expPix[$];
  bit         expDone[$];
  int  mPc = 0;
  bit  mOvf = 0;
  bit  mUnf = 0;
  bit  held = 0;
  logic [7:0] heldData = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // bench model of the expansion (R2, R3, R6, R7, R8)
  task automatic model(input int cnt, input int val, input bit last);
    bit wrapped = 0;
    for (int i = 0; i < cnt; i++) begin
      mPc++;
      expPix.push_back(8'(val));
      if (mPc == FP) begin
        expDone.push_back(1'b1);
        mPc = 0;
        wrapped = 1;
        if (i < cnt - 1) mOvf = 1;
        break;
      end else begin
        expDone.push_back(1'b0);
      end
    end
    if (last && mPc != 0) begin
      mUnf = 1;
      mPc = 0;
    end
  endtask

  task automatic putByte(input int b, input bit last);
    @(negedge clk);
    inValid = 1'b1;
    inData  = 8'(b);
    inLast  = last;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  // R1: count byte first, value byte second with the last bit
  task automatic sendRec(input int cnt, input int val, input bit last);
    model(cnt, val, last);
    putByte(cnt, 1'b0);
    putByte(val, last);
  endtask

  task automatic drain();
    while (expPix.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkFlags(input string tag);
    #2;
    check(overflowFlag == mOvf, {"R7 overflow ", tag}, overflowFlag, mOvf);
    check(underflowFlag == mUnf, {"R8 underflow ", tag}, underflowFlag, mUnf);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    expPix.delete();
    expDone.delete();
    mPc = 0; mOvf = 0; mUnf = 0;
    repeat (3) @(negedge clk);
    #1;
    check(inReady == 1'b1, "R9 inReady in reset", inReady, 1);
    check(outValid == 1'b0, "R9 outValid in reset", outValid, 0);
    check(frameDone == 1'b0, "R9 frameDone in reset", frameDone, 0);
    check(overflowFlag == 1'b0, "R9 overflow in reset", overflowFlag, 0);
    check(underflowFlag == 1'b0, "R9 underflow in reset", underflowFlag, 0);
    rstN = 1'b1;
  endtask

  // consumer: random ready, checks every handed-off pixel
  initial begin
    forever begin
      @(negedge clk);
      if (!rstN) begin
        outReady = 1'b0;
        held = 0;
        continue;
      end
      outReady = (($urandom % 100) < 32'(readyPct));
      #1;
      if (held) begin
        check(outValid == 1'b1 && outData == heldData, "R4 stall hold", outData, heldData);
      end
      if (outValid && inReady)
        check(1'b0, "R5 inReady while emitting", inReady, 0);
      held = outValid && !outReady;
      heldData = outData;
      if (outValid && outReady) begin
        if (expPix.size() == 0) begin
          check(1'b0, "R2 unexpected pixel", outData, -1);
        end else begin
          logic [7:0] ep;
          bit ed;
          ep = expPix.pop_front();
          ed = expDone.pop_front();
          check(outData == ep, "R2 pixel value", outData, ep);
          check(frameDone == ed, "R6 frameDone at handshake", frameDone, ed);
        end
      end else if (frameDone) begin
        check(1'b0, "R6 frameDone without handshake", frameDone, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    doReset();

    // directed: example records, a zero record, exact frame close (R1 R2 R3 R6)
    sendRec(6, 0, 0);
    sendRec(3, 255, 0);
    sendRec(0, 77, 0);
    sendRec(1, 120, 0);
    sendRec(14, 5, 1);
    drain();
    checkFlags("exact frame");

    // random fitting records, random stalls (R2 R3 R4 R5 R6)
    for (int f = 0; f < 30; f++) begin
      readyPct = (f % 3 == 0) ? 30 : ((f % 3 == 1) ? 100 : 70);
      while (1) begin
        int rem, mx, cnt;
        rem = FP - mPc;
        mx  = (rem < 9) ? rem : 9;
        cnt = $urandom_range(0, mx);
        sendRec(cnt, $urandom_range(0, 255), cnt == rem);
        if (cnt == rem) break;
      end
    end
    drain();
    checkFlags("random frames");

    // overflow straddling the frame boundary (R7), then a fresh frame starts
    readyPct = 60;
    doReset();
    sendRec(20, 1, 0);
    sendRec(10, 2, 0);
    drain();
    checkFlags("overflow");
    sendRec(24, 3, 1);
    drain();
    checkFlags("after overflow");

    // underflow: short last record, then zero-count last record (R8 R3)
    doReset();
    sendRec(5, 9, 1);
    drain();
    checkFlags("short last");
    sendRec(24, 4, 1);
    drain();
    checkFlags("frame after short");
    doReset();
    sendRec(2, 8, 0);
    sendRec(0, 0, 1);
    sendRec(24, 6, 1);
    drain();
    checkFlags("zero last");

    summary();
  end

endmodule